// File: doc/BRIEF.md
# Dual-Bank Configuration Image Validator

This block inspects two stored configuration images, one for each of two banks, as they stream past one byte per accepted cycle. Each bank holds `IMG_BYTES` bytes, 8 KiB by default. Bank 0 comes first in the stream and bank 1 follows directly after it. For each bank the block checks the identifying signature byte. It checks a short header sum that folds its carries back into 8 bits. It checks a 32-bit body checksum made of two running sums reduced modulo 65521. It also captures the bank's 32-bit generation number.

When the stream ends, the block reports which banks passed and the generation of each bank. A bank that failed reports generation 0. The block also names the active bank: the bank holding the newer image, with bank 0 winning ties. A one-cycle done pulse marks the moment the results are final. The results then stay unchanged until the next stream begins.

Top module: `nvram_bank_picker`

## Requirements
- R1: A byte with `in_valid` and `in_start` both high is offset 0 of bank 0, and it begins a new session. Later valid bytes take consecutive offsets: offsets 0 to `IMG_BYTES-1` belong to bank 0 and the next `IMG_BYTES` bytes belong to bank 1. Valid bytes that arrive outside a session are ignored.
- R2: A bank can pass only if its byte at offset 0 equals 0x5A.
- R3: The header sum is the 16-bit sum of the byte at offset 0 and the bytes at offsets 2 to 15. Folding replaces the value with its low byte plus its high byte, and this repeats until the value fits in 8 bits. A bank passes only if the folded result equals the byte at offset 1.
- R4: The body checksum runs over offsets 0x14 to `IMG_BYTES-1`. The low sum starts at 1 and the high sum at 0. For each byte, the byte is added to the low sum and then the low sum is added to the high sum, with both sums taken modulo 65521. The result is {high, low}. A bank passes only if this result equals the big-endian word at offsets 0x10 to 0x13.
- R5: The generation is the big-endian word at offsets 0x14 to 0x17. `bank_ok[b]` is 1 for a passing bank b, and `gen_bankb` then carries that bank's generation. A failing bank has `bank_ok[b]` = 0 and `gen_bankb` = 0.
- R6: `active_bank` is 1 only when `gen_bank0` is strictly less than `gen_bank1`, and it is 0 otherwise.
- R7: `done` is high for exactly one cycle, in the cycle after the byte carrying `in_last` is accepted. The results hold until the next start byte. A start byte clears both `bank_ok` bits and both generations to 0.
- R8: If `in_last` arrives before a bank has received all of its bytes, that bank reports failure. Bytes beyond offset `2*IMG_BYTES-1` that arrive before `in_last` are ignored.
- R9: After reset, `done`, `bank_ok`, both generations and `active_bank` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_start | input | 1 | Marks the first byte of a session |
| in_valid | input | 1 | Byte on `in_byte` is valid this cycle |
| in_last | input | 1 | Marks the final byte of a session |
| in_byte | input | 8 | Stream data |
| done | output | 1 | One-cycle pulse: results are final |
| bank_ok | output | 2 | Per-bank pass flags, bit b for bank b |
| gen_bank0 | output | 32 | Generation of bank 0, 0 if it failed |
| gen_bank1 | output | 32 | Generation of bank 1, 0 if it failed |
| active_bank | output | 1 | Index of the bank holding the newer image |

## Verification
The bench goes after the corner cases below. Random header bytes push the header sum past 255, so a design that drops the end-around carry would reject good banks. A body filled with 0xFF drives both running sums past the modulus many times, so a missing or misplaced modular reduction would corrupt the checksum. Equal generations check that a design using a non-strict comparison would wrongly select bank 1. The bench also covers a corrupted signature, a corrupted header sum and a corrupted body byte, each on a bank with the larger generation, so that a design that ignores one of the checks would report a bogus generation or the wrong active bank. Finally, it covers a stream cut short by an early `in_last`, a stream that overruns its length, and valid bytes sent after a session ends. These catch a design whose counter wraps into a bank, or whose results change without a new start.

// File: rtl/nvram_bank_picker.sv
module nvram_bank_picker #(
  parameter int IMG_BYTES = 8192,
  parameter logic [7:0] SIG = 8'h5A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_start,
  input  logic        in_valid,
  input  logic        in_last,
  input  logic [7:0]  in_byte,
  output logic        done,
  output logic [1:0]  bank_ok,
  output logic [31:0] gen_bank0,
  output logic [31:0] gen_bank1,
  output logic        active_bank
);
  localparam int AW = $clog2(IMG_BYTES);
  localparam int CW = AW + 2;
  localparam logic [16:0] MODV = 17'd65521;
  localparam logic [AW-1:0] OFF_END = AW'(IMG_BYTES - 1);
  localparam logic [AW-1:0] OFF_BODY = AW'(20);

  logic [CW-1:0] pos;
  logic          busy;
  logic          sig_ok;
  logic [15:0]   hsum;
  logic [7:0]    hck;
  logic [31:0]   body_ref;
  logic [31:0]   gen_w;
  logic [15:0]   lo, hi;
  logic [31:0]   gen_r [2];

  wire            take     = in_valid & (in_start | busy);
  wire [CW-1:0]   idx      = in_start ? '0 : pos;
  wire            in_range = idx < CW'(2 * IMG_BYTES);
  wire            acc      = take & in_range;
  wire            bsel     = idx[AW];
  wire [AW-1:0]   off      = idx[AW-1:0];

  wire [16:0] lo_add = {1'b0, lo} + {9'b0, in_byte};
  wire [15:0] lo_n   = (lo_add >= MODV) ? 16'(lo_add - MODV) : lo_add[15:0];
  wire [16:0] hi_add = {1'b0, hi} + {1'b0, lo_n};
  wire [15:0] hi_n   = (hi_add >= MODV) ? 16'(hi_add - MODV) : hi_add[15:0];

  wire [8:0]  fold1  = {1'b0, hsum[7:0]} + {1'b0, hsum[15:8]};
  wire [8:0]  fold2  = {1'b0, fold1[7:0]} + {8'b0, fold1[8]};
  wire        pass   = sig_ok && (fold2[7:0] == hck) && ({hi_n, lo_n} == body_ref);
  wire        finish = acc && (off == OFF_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= take & in_last;
      if (acc) pos <= idx + CW'(1);
      else if (take) pos <= idx;
      if (take && in_last) busy <= 1'b0;
      else if (in_valid && in_start) busy <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_ok   <= 1'b0;
      hsum     <= '0;
      hck      <= '0;
      body_ref <= '0;
      gen_w    <= '0;
      lo       <= 16'd1;
      hi       <= '0;
    end else if (acc) begin
      if (off == '0) begin
        sig_ok <= (in_byte == SIG);
        hsum   <= {8'b0, in_byte};
      end
      if (off == AW'(1)) hck <= in_byte;
      if (off >= AW'(2) && off <= AW'(15)) hsum <= hsum + {8'b0, in_byte};
      if (off >= AW'(16) && off <= AW'(19)) body_ref <= {body_ref[23:0], in_byte};
      if (off >= AW'(20) && off <= AW'(23)) gen_w <= {gen_w[23:0], in_byte};
      if (off < OFF_BODY) begin
        lo <= 16'd1;
        hi <= '0;
      end else begin
        lo <= lo_n;
        hi <= hi_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_ok  <= '0;
      gen_r[0] <= '0;
      gen_r[1] <= '0;
    end else if (in_valid && in_start) begin
      bank_ok  <= '0;
      gen_r[0] <= '0;
      gen_r[1] <= '0;
    end else if (finish) begin
      bank_ok[bsel] <= pass;
      gen_r[bsel]   <= pass ? gen_w : '0;
    end
  end

  assign gen_bank0   = gen_r[0];
  assign gen_bank1   = gen_r[1];
  assign active_bank = gen_r[0] < gen_r[1];
endmodule

// File: rtl/nvram_bank_picker_chk.sv
module nvram_bank_picker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_start,
  input logic        in_valid,
  input logic        in_last,
  input logic        done,
  input logic [1:0]  bank_ok,
  input logic [31:0] gen_bank0,
  input logic [31:0] gen_bank1,
  input logic        active_bank
);
  // R7
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid && in_last));
  // R7
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_start) |=> (bank_ok == 2'b00 && gen_bank0 == 0 && gen_bank1 == 0));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(bank_ok) && $stable(gen_bank0) && $stable(gen_bank1)));
  // R5
  fail0_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_ok[0] |-> gen_bank0 == 0);
  // R5
  fail1_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_ok[1] |-> gen_bank1 == 0);
  // R6
  active_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_bank |-> bank_ok[1]);
endmodule

bind nvram_bank_picker nvram_bank_picker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_start(in_start), .in_valid(in_valid),
  .in_last(in_last), .done(done), .bank_ok(bank_ok), .gen_bank0(gen_bank0),
  .gen_bank1(gen_bank1), .active_bank(active_bank)
);

// File: tb/nvram_bank_picker_tb.sv
`timescale 1ns/1ps
module nvram_bank_picker_tb;
  localparam int IMG = 8192;
  logic clk = 0, rst_n = 0;
  logic in_start = 0, in_valid = 0, in_last = 0;
  logic [7:0] in_byte = 0;
  logic done, active_bank;
  logic [1:0] bank_ok;
  logic [31:0] gen_bank0, gen_bank1;

  nvram_bank_picker u_dut (.*);

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  logic [7:0] bk [2][IMG];
  bit e_ok [2];
  int unsigned e_gen [2];
  bit x_ok [2];
  int unsigned x_gen [2];
  bit x_done = 0;
  bit mon_en = 0;
  int unsigned lcg;

  task automatic chk(string tag, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (mon_en) begin
    chk("R7 done (cycle)", done, x_done);
    chk("R5 bank_ok0 (cycle)", bank_ok[0], x_ok[0]);
    chk("R5 bank_ok1 (cycle)", bank_ok[1], x_ok[1]);
    chk("R5 gen_bank0 (cycle)", gen_bank0, x_gen[0]);
    chk("R5 gen_bank1 (cycle)", gen_bank1, x_gen[1]);
    chk("R6 active_bank (cycle)", active_bank, (x_gen[1] > x_gen[0]) ? 1 : 0);
  end

  function automatic int unsigned hdr_fold(int b);
    int unsigned s = bk[b][0];
    for (int i = 2; i < 16; i++) s += bk[b][i];
    while (s > 255) s = (s & 255) + (s >> 8);
    return s;
  endfunction

  function automatic int unsigned body_sum(int b);
    longint unsigned l = 1, h = 0;
    for (int i = 20; i < IMG; i++) begin
      l += bk[b][i];
      h += l;
    end
    return int'(((h % 65521) << 16) | (l % 65521));
  endfunction

  function automatic int unsigned word_at(int b, int o);
    return {bk[b][o], bk[b][o+1], bk[b][o+2], bk[b][o+3]};
  endfunction

  task automatic evaluate(int b);
    bit ok;
    ok = (bk[b][0] == 8'h5A) && (hdr_fold(b) == bk[b][1]) && (body_sum(b) == word_at(b, 16));
    e_ok[b] = ok;
    e_gen[b] = ok ? word_at(b, 20) : 0;
  endtask

  // mode: 0 good, 1 bad signature, 2 bad header sum, 3 bad body, 4 0xFF body
  task automatic build(int b, int unsigned gen, int mode);
    int unsigned c, s;
    for (int i = 0; i < IMG; i++) begin
      lcg = lcg * 1103515245 + 12345;
      bk[b][i] = lcg[23:16];
    end
    bk[b][0] = 8'h5A;
    {bk[b][20], bk[b][21], bk[b][22], bk[b][23]} = gen;
    if (mode == 4) for (int i = 24; i < IMG; i++) bk[b][i] = 8'hFF;
    bk[b][1] = 8'(hdr_fold(b));
    s = bk[b][0];
    for (int i = 2; i < 16; i++) s += bk[b][i];
    c = body_sum(b);
    {bk[b][16], bk[b][17], bk[b][18], bk[b][19]} = c;
    if (mode == 1) bk[b][0] = 8'h5B;
    if (mode == 2) bk[b][1] = bk[b][1] ^ 8'h01;
    if (mode == 3) bk[b][500] = bk[b][500] ^ 8'h10;
    if (b == 0 && s < 256) $display("note: header sum did not need folding");
    evaluate(b);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0; in_start = 0; in_last = 0;
    @(posedge clk); #1;
    x_done = 0;
  endtask

  task automatic send(int n, int gap);
    for (int i = 0; i < n; i++) begin
      if (gap != 0 && (i % gap) == gap - 1) idle();
      @(negedge clk);
      in_valid = 1;
      in_start = (i == 0);
      in_last  = (i == n - 1);
      in_byte  = (i < IMG) ? bk[0][i] : (i < 2*IMG) ? bk[1][i-IMG] : 8'hA5;
      @(posedge clk); #1;
      if (i == 0) begin
        x_ok[0] = 0; x_ok[1] = 0; x_gen[0] = 0; x_gen[1] = 0;
      end
      if (i == IMG - 1) begin x_ok[0] = e_ok[0]; x_gen[0] = e_gen[0]; end
      if (i == 2*IMG - 1) begin x_ok[1] = e_ok[1]; x_gen[1] = e_gen[1]; end
      x_done = (i == n - 1);
    end
    idle();
  endtask

  task automatic final_chk(string tag, bit ok0, bit ok1, int unsigned g0, int unsigned g1, bit act);
    @(negedge clk);
    chk({tag, " bank_ok0"}, bank_ok[0], ok0);
    chk({tag, " bank_ok1"}, bank_ok[1], ok1);
    chk({tag, " gen_bank0"}, gen_bank0, g0);
    chk({tag, " gen_bank1"}, gen_bank1, g1);
    chk({tag, " active_bank"}, active_bank, act);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog expired: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    lcg = 32'h1234_5678;
    x_ok[0] = 0; x_ok[1] = 0; x_gen[0] = 0; x_gen[1] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset done", done, 0);
    chk("R9 reset bank_ok", bank_ok, 0);
    chk("R9 reset gen0", gen_bank0, 0);
    chk("R9 reset gen1", gen_bank1, 0);
    chk("R9 reset active", active_bank, 0);
    rst_n = 1;
    mon_en = 1;
    idle();

    // R1 R4 R5 R6: both good, bank 1 newer
    build(0, 5, 0); build(1, 9, 0);
    send(2*IMG, 0);
    final_chk("R6 newer bank1", 1, 1, 5, 9, 1);

    // R8: overlong stream, extra bytes ignored; R6 bank0 newer
    build(0, 32'h8000_0009, 0); build(1, 5, 0);
    send(2*IMG + 5, 0);
    final_chk("R8 overrun", 1, 1, 32'h8000_0009, 5, 0);

    // R6: equal generations keep bank 0
    build(0, 7, 0); build(1, 7, 0);
    send(2*IMG, 0);
    final_chk("R6 tie", 1, 1, 7, 7, 0);

    // R2: bad signature on newer bank
    build(0, 4, 0); build(1, 100, 1);
    send(2*IMG, 0);
    final_chk("R2 bad sig", 1, 0, 4, 0, 0);

    // R3: bad header sum on newer bank 0
    build(0, 200, 2); build(1, 3, 0);
    send(2*IMG, 0);
    final_chk("R3 bad hdr", 0, 1, 0, 3, 1);

    // R4: corrupted body in bank 0, all-0xFF body in bank 1, with gaps
    build(0, 50, 3); build(1, 2, 4);
    send(2*IMG, 7);
    final_chk("R4 body", 0, 1, 0, 2, 1);

    // R1: valid bytes with no session are ignored
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      in_valid = 1; in_start = 0; in_last = (k == 9); in_byte = 8'h5A;
      @(posedge clk); #1;
      x_done = 0;
    end
    idle();
    final_chk("R1 ignored", 0, 1, 0, 2, 1);

    // R8: early last cuts bank 1 short
    build(0, 11, 0); build(1, 99, 0);
    send(IMG + 100, 0);
    final_chk("R8 short", 1, 0, 11, 0, 0);

    repeat (3) idle();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule